// File: doc/BRIEF.md
# Stack frame save/restore sequencer

This block carries out a procedure-entry save or a procedure-exit restore of a register group as a short burst of word transfers. A stack-pointer adjustment ends each operation. A single start pulse supplies the operation as a set of fields. The fields give the direction, three single-register enables (return address, s0, s1), an extra-register count from 0 to 7, a 4-bit argument code and a frame size in bytes. The caller's stack pointer comes in with them. The block then drives a word memory port and a register-file port, one memory access per cycle. It writes the new stack pointer and pulses done.

The argument code has two meanings. It gives the number of argument registers (4 upward) that a save stores above the stack pointer. It also gives the number of static registers (7 downward) that follow the saved group. On a save, the argument stores go upward from SP. All other transfers go downward, and the pointer drops by one word before each access. The order of those transfers is fixed: return address, then the extra registers, then s1, s0 and the statics. A restore walks the same order, starting from SP plus the frame size. It skips the argument slots and sign-extends each loaded word to the register width.

The memory returns read data one cycle after the request, so each loaded register is written one cycle after its load. The state machine has six states. IDLE leaves on an accepted start. It goes to REJECT on the reserved code. Otherwise it goes to ARGS when argument stores are due, to FRAME when any downward transfer is due, and to ADJUST otherwise. ARGS moves to FRAME after its last store, or to ADJUST when no downward transfer is enabled. FRAME moves to ADJUST after its last transfer. ADJUST writes the stack pointer and moves to DONE. DONE and REJECT each last one cycle and return to IDLE.

Top module: `frame_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, mem_en_o, rf_we_o and sp_we_o are all low.
- R2: On a save, the first accesses are argument stores. Store i (i = 0 upward) goes to address SP+4*i and takes the low word of register 4+i. The number of stores depends on the argument code. Codes 0, 1, 2, 3 and 11 give 0 stores. Codes 4 to 7 give 1. Codes 8 to 10 give 2. Codes 12 and 13 give 3. Code 14 gives 4.
- R3: After the argument stores, each access uses an address one word (4 bytes) below the previous downward access. The first downward access goes to the pointer start minus 4. For a save, the pointer starts at SP. The register order is: 31 if its enable is set, then the extra registers, then 17 if its enable is set, then 16 if its enable is set, then the statics.
- R4: With extra count n, the last n entries of the list 30, 23, 22, 21, 20, 19, 18 are transferred, in list order. For example, n = 2 gives 19 then 18, and n = 7 gives all seven.
- R5: The static count depends on the argument code. Codes 0, 4, 8, 12 and 14 give 0. Codes 1, 5, 9 and 13 give 1. Codes 2, 6 and 10 give 2. Codes 3 and 7 give 3. Code 11 gives 4. The statics are registers 7, 6, 5 and 4, taken in that order up to the count.
- R6: Accesses occupy consecutive cycles. The first access comes in the cycle after the start edge. In the cycle after the last access, sp_we_o is high for one cycle with sp_new_o equal to SP minus the frame size on a save, or SP plus the frame size on a restore. done_o is high alone in the next cycle. With no transfers, sp_we_o comes in the first cycle after start.
- R7: A restore performs loads only (mem_we_o low). It uses the R3 order and step, but the pointer starts at SP plus the frame size. It makes no argument-slot access.
- R8: Each loaded 32-bit word is sign-extended to 64 bits and written to its register one cycle after the load request.
- R9: Argument code 15 is reserved. It makes no memory access, no register write and no stack-pointer write. In the cycle after the start edge, done_o and err_o are high together for one cycle.
- R10: A start pulse while busy_o is high is ignored. The running operation's accesses, data and new stack pointer are those of the original request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| save_i | input | 1 | 1 = save, 0 = restore |
| keep_ra_i | input | 1 | Include register 31 |
| keep_s0_i | input | 1 | Include register 16 |
| keep_s1_i | input | 1 | Include register 17 |
| xtra_cnt_i | input | 3 | Extra-register count 0..7 |
| arg_code_i | input | 4 | Argument/static code, 15 reserved |
| frame_i | input | FRAME_W | Frame size in bytes |
| sp_i | input | ADDR_W | Current stack pointer |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Reserved-code indication, with done_o |
| mem_en_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = store, 0 = load |
| mem_addr_o | output | ADDR_W | Byte address of the word |
| mem_wdata_o | output | WORD_W | Store data |
| mem_rdata_i | input | WORD_W | Load data, valid one cycle after request |
| rf_raddr_o | output | 5 | Register-file read index |
| rf_rdata_i | input | REG_W | Register-file read data (combinational) |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write index |
| rf_wdata_o | output | REG_W | Sign-extended load data |
| sp_we_o | output | 1 | Stack-pointer write strobe |
| sp_new_o | output | ADDR_W | New stack-pointer value |

## Verification
The bench targets these corner cases:
- The code pairs that share an argument count but differ in static count, such as 11 against 0 and 13 against 12. A decoder that mixed up the two tables would store argument words that should not exist, or drop static registers.
- An extra count of 7, with every single enable set. An off-by-one in the extra-register window would lose register 30 or shift every later address by a word.
- A restore over memory words with the top bit set. These expose a zero-extension error.
- A restore with a non-zero argument count. This shows whether argument slots are wrongly reloaded.
- An operation with no transfers, a reserved code, and a second start pulse during a save. These catch a missing stack-pointer cycle, a reserved code that still moves the stack pointer, and a restart that corrupts a running operation.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

    // Fixed encoding of the downward transfer list.
    localparam int SLOT_N = 14;
    localparam int ARG_N  = 4;
    localparam int RIDX_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARGS,
        ST_FRAME,
        ST_ADJUST,
        ST_DONE,
        ST_REJECT
    } seq_state_t;

    // Slot position to register index; the position is the transfer order.
    function automatic logic [RIDX_W-1:0] slot_reg(input logic [3:0] slot);
        logic [RIDX_W-1:0] r;
        unique case (slot)
            4'd0:    r = 5'd31;
            4'd1:    r = 5'd30;
            4'd2:    r = 5'd23;
            4'd3:    r = 5'd22;
            4'd4:    r = 5'd21;
            4'd5:    r = 5'd20;
            4'd6:    r = 5'd19;
            4'd7:    r = 5'd18;
            4'd8:    r = 5'd17;
            4'd9:    r = 5'd16;
            4'd10:   r = 5'd7;
            4'd11:   r = 5'd6;
            4'd12:   r = 5'd5;
            4'd13:   r = 5'd4;
            default: r = 5'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/frame_code_dec.sv
module frame_code_dec (
    input  logic [3:0] code_i,
    output logic [2:0] arg_cnt_o,
    output logic [2:0] stat_cnt_o,
    output logic       reserved_o
);
    always_comb begin
        arg_cnt_o  = 3'd0;
        stat_cnt_o = 3'd0;
        reserved_o = 1'b0;
        unique case (code_i)
            4'd0:  begin arg_cnt_o = 3'd0; stat_cnt_o = 3'd0; end
            4'd1:  begin arg_cnt_o = 3'd0; stat_cnt_o = 3'd1; end
            4'd2:  begin arg_cnt_o = 3'd0; stat_cnt_o = 3'd2; end
            4'd3:  begin arg_cnt_o = 3'd0; stat_cnt_o = 3'd3; end
            4'd4:  begin arg_cnt_o = 3'd1; stat_cnt_o = 3'd0; end
            4'd5:  begin arg_cnt_o = 3'd1; stat_cnt_o = 3'd1; end
            4'd6:  begin arg_cnt_o = 3'd1; stat_cnt_o = 3'd2; end
            4'd7:  begin arg_cnt_o = 3'd1; stat_cnt_o = 3'd3; end
            4'd8:  begin arg_cnt_o = 3'd2; stat_cnt_o = 3'd0; end
            4'd9:  begin arg_cnt_o = 3'd2; stat_cnt_o = 3'd1; end
            4'd10: begin arg_cnt_o = 3'd2; stat_cnt_o = 3'd2; end
            4'd11: begin arg_cnt_o = 3'd0; stat_cnt_o = 3'd4; end
            4'd12: begin arg_cnt_o = 3'd3; stat_cnt_o = 3'd0; end
            4'd13: begin arg_cnt_o = 3'd3; stat_cnt_o = 3'd1; end
            4'd14: begin arg_cnt_o = 3'd4; stat_cnt_o = 3'd0; end
            default: reserved_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/frame_mask_gen.sv
module frame_mask_gen
    import frame_seq_pkg::*;
(
    input  logic              save_i,
    input  logic              keep_ra_i,
    input  logic              keep_s0_i,
    input  logic              keep_s1_i,
    input  logic [2:0]        xtra_cnt_i,
    input  logic [2:0]        arg_cnt_i,
    input  logic [2:0]        stat_cnt_i,
    output logic [ARG_N-1:0]  arg_mask_o,
    output logic [SLOT_N-1:0] slot_mask_o
);
    localparam int XTRA_N = 7;
    localparam int STAT_N = 4;
    localparam int XTRA_BASE = 1;
    localparam int STAT_BASE = XTRA_BASE + XTRA_N + 2;

    // Argument stores exist only on save.
    for (genvar i = 0; i < ARG_N; i++) begin : g_arg
        assign arg_mask_o[i] = save_i && (arg_cnt_i > 3'(i));
    end

    assign slot_mask_o[0] = keep_ra_i;

    // Extra window: the last n entries of the seven-entry list.
    for (genvar j = 0; j < XTRA_N; j++) begin : g_xtra
        assign slot_mask_o[XTRA_BASE+j] = (xtra_cnt_i >= 3'(XTRA_N - j));
    end

    assign slot_mask_o[XTRA_BASE+XTRA_N]   = keep_s1_i;
    assign slot_mask_o[XTRA_BASE+XTRA_N+1] = keep_s0_i;

    for (genvar k = 0; k < STAT_N; k++) begin : g_stat
        assign slot_mask_o[STAT_BASE+k] = (stat_cnt_i > 3'(k));
    end
endmodule

// File: rtl/frame_pick.sv
module frame_pick #(
    parameter int W = 14,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  mask_i,
    output logic [IW-1:0] idx_o,
    output logic [W-1:0]  rest_o
);
    // Lowest set bit first; rest_o is the mask with that bit removed.
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = IW'(i);
        end
    end

    assign rest_o = mask_i & (mask_i - W'(1));
endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import frame_seq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int WORD_W  = 32,
    parameter int REG_W   = 64,
    parameter int FRAME_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               save_i,
    input  logic               keep_ra_i,
    input  logic               keep_s0_i,
    input  logic               keep_s1_i,
    input  logic [2:0]         xtra_cnt_i,
    input  logic [3:0]         arg_code_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic [ADDR_W-1:0]  sp_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               err_o,
    output logic               mem_en_o,
    output logic               mem_we_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [WORD_W-1:0]  mem_wdata_o,
    input  logic [WORD_W-1:0]  mem_rdata_i,
    output logic [RIDX_W-1:0]  rf_raddr_o,
    input  logic [REG_W-1:0]   rf_rdata_i,
    output logic               rf_we_o,
    output logic [RIDX_W-1:0]  rf_waddr_o,
    output logic [REG_W-1:0]   rf_wdata_o,
    output logic               sp_we_o,
    output logic [ADDR_W-1:0]  sp_new_o
);
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int STEP_SH    = $clog2(WORD_BYTES);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
    localparam int AIW = $clog2(ARG_N);
    localparam int SIW = $clog2(SLOT_N);

    seq_state_t state_q, state_d;

    logic [2:0]        arg_cnt, stat_cnt;
    logic              reserved;
    logic [ARG_N-1:0]  arg_mask, arg_left_q, arg_rest;
    logic [SLOT_N-1:0] slot_mask, slot_left_q, slot_rest;
    logic [AIW-1:0]    arg_idx;
    logic [SIW-1:0]    slot_idx;
    logic              save_q;
    logic [ADDR_W-1:0] sp_q, ptr_q;
    logic [FRAME_W-1:0] frame_q;
    logic              ld_pend_q;
    logic [RIDX_W-1:0] ld_reg_q;
    logic              accept;

    frame_code_dec u_dec (
        .code_i     (arg_code_i),
        .arg_cnt_o  (arg_cnt),
        .stat_cnt_o (stat_cnt),
        .reserved_o (reserved)
    );

    frame_mask_gen u_mask (
        .save_i      (save_i),
        .keep_ra_i   (keep_ra_i),
        .keep_s0_i   (keep_s0_i),
        .keep_s1_i   (keep_s1_i),
        .xtra_cnt_i  (xtra_cnt_i),
        .arg_cnt_i   (arg_cnt),
        .stat_cnt_i  (stat_cnt),
        .arg_mask_o  (arg_mask),
        .slot_mask_o (slot_mask)
    );

    frame_pick #(.W(ARG_N)) u_pick_arg (
        .mask_i (arg_left_q),
        .idx_o  (arg_idx),
        .rest_o (arg_rest)
    );

    frame_pick #(.W(SLOT_N)) u_pick_slot (
        .mask_i (slot_left_q),
        .idx_o  (slot_idx),
        .rest_o (slot_rest)
    );

    assign accept = start_i && (state_q == ST_IDLE);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (reserved)               state_d = ST_REJECT;
                    else if (arg_mask != '0)    state_d = ST_ARGS;
                    else if (slot_mask != '0)   state_d = ST_FRAME;
                    else                        state_d = ST_ADJUST;
                end
            end
            ST_ARGS: begin
                if (arg_rest == '0)
                    state_d = (slot_left_q != '0) ? ST_FRAME : ST_ADJUST;
            end
            ST_FRAME: begin
                if (slot_rest == '0) state_d = ST_ADJUST;
            end
            ST_ADJUST: state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            ST_REJECT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Operation context and walk bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_q      <= 1'b0;
            sp_q        <= '0;
            frame_q     <= '0;
            ptr_q       <= '0;
            arg_left_q  <= '0;
            slot_left_q <= '0;
            ld_pend_q   <= 1'b0;
            ld_reg_q    <= '0;
        end else begin
            ld_pend_q <= (state_q == ST_FRAME) && !save_q;
            ld_reg_q  <= slot_reg(4'(slot_idx));
            if (accept) begin
                save_q      <= save_i;
                sp_q        <= sp_i;
                frame_q     <= frame_i;
                ptr_q       <= save_i ? sp_i : sp_i + ADDR_W'(frame_i);
                arg_left_q  <= reserved ? '0 : arg_mask;
                slot_left_q <= reserved ? '0 : slot_mask;
            end else if (state_q == ST_ARGS) begin
                arg_left_q <= arg_rest;
            end else if (state_q == ST_FRAME) begin
                slot_left_q <= slot_rest;
                ptr_q       <= ptr_q - STEP;
            end
        end
    end

    // Outputs decoded from state.
    always_comb begin
        busy_o     = (state_q != ST_IDLE);
        done_o     = 1'b0;
        err_o      = 1'b0;
        mem_en_o   = 1'b0;
        mem_we_o   = 1'b0;
        mem_addr_o = '0;
        rf_raddr_o = '0;
        sp_we_o    = 1'b0;
        sp_new_o   = sp_q;
        unique case (state_q)
            ST_IDLE: ;
            ST_ARGS: begin
                mem_en_o   = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = sp_q + (ADDR_W'(arg_idx) << STEP_SH);
                rf_raddr_o = RIDX_W'(4) + RIDX_W'(arg_idx);
            end
            ST_FRAME: begin
                mem_en_o   = 1'b1;
                mem_we_o   = save_q;
                mem_addr_o = ptr_q - STEP;
                rf_raddr_o = slot_reg(4'(slot_idx));
            end
            ST_ADJUST: begin
                sp_we_o  = 1'b1;
                sp_new_o = save_q ? sp_q - ADDR_W'(frame_q)
                                  : sp_q + ADDR_W'(frame_q);
            end
            ST_DONE:   done_o = 1'b1;
            ST_REJECT: begin
                done_o = 1'b1;
                err_o  = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_wdata_o = rf_rdata_i[WORD_W-1:0];
    assign rf_we_o     = ld_pend_q;
    assign rf_waddr_o  = ld_reg_q;

    if (REG_W > WORD_W) begin : g_sext
        logic rdata_unused;
        assign rdata_unused = ^rf_rdata_i[REG_W-1:WORD_W];
        assign rf_wdata_o = {{(REG_W-WORD_W){mem_rdata_i[WORD_W-1]}}, mem_rdata_i};
    end else begin : g_same
        assign rf_wdata_o = mem_rdata_i;
    end

    // Assertions.
    a_r9_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (arg_code_i == 4'd15))
        |=> (done_o && err_o && !mem_en_o && !sp_we_o && !rf_we_o));

    a_r6_done_after_sp: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> $past(sp_we_o));

    a_r8_write_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |-> $past(mem_en_o && !mem_we_o));

    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en_o && state_q == ST_FRAME)
        |=> (state_q != ST_FRAME) || (mem_addr_o == $past(mem_addr_o) - STEP));

    a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o) |=> ($stable(save_q) && $stable(sp_q) && $stable(frame_q)));

endmodule

// File: tb/tb_frame_seq.sv
module tb_frame_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, save_i = 1'b0;
    logic        keep_ra_i = 1'b0, keep_s0_i = 1'b0, keep_s1_i = 1'b0;
    logic [2:0]  xtra_cnt_i = '0;
    logic [3:0]  arg_code_i = '0;
    logic [11:0] frame_i = '0;
    logic [31:0] sp_i = '0;
    logic        busy_o, done_o, err_o, mem_en_o, mem_we_o, rf_we_o, sp_we_o;
    logic [31:0] mem_addr_o, mem_wdata_o, sp_new_o;
    logic [31:0] mem_rdata_i = '0;
    logic [4:0]  rf_raddr_o, rf_waddr_o;
    logic [63:0] rf_rdata_i, rf_wdata_o;

    always #2 clk = ~clk;

    frame_seq dut (.*);

    logic [31:0] mem [0:255];
    logic [63:0] rf  [0:31];
    assign rf_rdata_i = rf[rf_raddr_o];

    always @(posedge clk) begin
        if (mem_en_o && mem_we_o)  mem[mem_addr_o[9:2]] <= mem_wdata_o;
        if (mem_en_o && !mem_we_o) mem_rdata_i <= mem[mem_addr_o[9:2]];
        if (rf_we_o) rf[rf_waddr_o] <= rf_wdata_o;
    end

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected transfer list, built from the requirements.
    logic [31:0] e_addr [0:31];
    logic [4:0]  e_reg  [0:31];
    int          e_n;
    logic [31:0] p;
    logic [31:0] l_addr [0:31];
    logic [31:0] l_data [0:31];
    logic        l_we   [0:31];
    int          l_cyc  [0:31];
    int          l_n;

    task automatic add_down(input logic [4:0] r);
        p = p - 32'd4;
        e_addr[e_n] = p; e_reg[e_n] = r; e_n++;
    endtask

    task automatic build(input bit sv, ra, s0, s1, input [2:0] xc, input [3:0] code,
                         input [11:0] fr, input [31:0] sp);
        int acnt, scnt;
        logic [4:0] xr [0:6];
        xr = '{5'd30, 5'd23, 5'd22, 5'd21, 5'd20, 5'd19, 5'd18};
        case (code)
            4'd4, 4'd5, 4'd6, 4'd7: acnt = 1;
            4'd8, 4'd9, 4'd10:      acnt = 2;
            4'd12, 4'd13:           acnt = 3;
            4'd14:                  acnt = 4;
            default:                acnt = 0;
        endcase
        case (code)
            4'd1, 4'd5, 4'd9, 4'd13: scnt = 1;
            4'd2, 4'd6, 4'd10:       scnt = 2;
            4'd3, 4'd7:              scnt = 3;
            4'd11:                   scnt = 4;
            default:                 scnt = 0;
        endcase
        e_n = 0;
        if (code == 4'd15) return;
        if (sv) for (int i = 0; i < acnt; i++) begin
            e_addr[e_n] = sp + 32'(4 * i); e_reg[e_n] = 5'(4 + i); e_n++;
        end
        p = sv ? sp : sp + 32'(fr);
        if (ra) add_down(5'd31);
        for (int j = 0; j < 7; j++) if (j >= 7 - int'(xc)) add_down(xr[j]);
        if (s1) add_down(5'd17);
        if (s0) add_down(5'd16);
        for (int j = 0; j < scnt; j++) add_down(5'(7 - j));
    endtask

    task automatic run_op(input bit sv, ra, s0, s1, input [2:0] xc, input [3:0] code,
                          input [11:0] fr, input [31:0] sp, input bit poke, input string tag);
        int sp_cyc, done_cyc, rf_writes;
        logic [31:0] sp_val;
        logic err_seen;
        logic [31:0] snap [0:255];
        build(sv, ra, s0, s1, xc, code, fr, sp);
        for (int i = 0; i < 256; i++) snap[i] = mem[i];
        @(negedge clk);
        start_i = 1; save_i = sv; keep_ra_i = ra; keep_s0_i = s0; keep_s1_i = s1;
        xtra_cnt_i = xc; arg_code_i = code; frame_i = fr; sp_i = sp;
        @(negedge clk);
        start_i = 0;
        l_n = 0; sp_cyc = -1; done_cyc = -1; sp_val = '0; err_seen = 0; rf_writes = 0;
        for (int cyc = 1; cyc < 60; cyc++) begin
            if (mem_en_o) begin
                l_addr[l_n] = mem_addr_o; l_data[l_n] = mem_wdata_o;
                l_we[l_n] = mem_we_o; l_cyc[l_n] = cyc; l_n++;
            end
            if (rf_we_o) rf_writes++;
            if (sp_we_o) begin sp_cyc = cyc; sp_val = sp_new_o; end
            if (done_o) begin done_cyc = cyc; err_seen = err_o; end
            if (poke && cyc == 2) begin
                start_i = 1; save_i = ~sv; arg_code_i = 4'd0; sp_i = 32'h300; frame_i = 12'h10;
            end else begin
                start_i = 0;
            end
            @(negedge clk);
            if (done_cyc > 0) break;
        end
        start_i = 0;
        chk(l_n == e_n, {tag, " access count"}, 64'(l_n), 64'(e_n));
        for (int k = 0; k < e_n && k < l_n; k++) begin
            chk(l_addr[k] == e_addr[k], {tag, " address"}, 64'(l_addr[k]), 64'(e_addr[k]));
            chk(l_we[k] == sv, {tag, " direction"}, 64'(l_we[k]), 64'(sv));
            chk(l_cyc[k] == k + 1, {tag, " R6 cycle"}, 64'(l_cyc[k]), 64'(k + 1));
            if (sv)
                chk(l_data[k] == rf[e_reg[k]][31:0], {tag, " store data"},
                    64'(l_data[k]), 64'(rf[e_reg[k]][31:0]));
            else
                chk(rf[e_reg[k]] == {{32{snap[e_addr[k][9:2]][31]}}, snap[e_addr[k][9:2]]},
                    {tag, " R8 loaded value"}, rf[e_reg[k]],
                    {{32{snap[e_addr[k][9:2]][31]}}, snap[e_addr[k][9:2]]});
        end
        if (code == 4'd15) begin
            chk(sp_cyc == -1, {tag, " R9 no sp write"}, 64'(sp_cyc), 64'hFFFF_FFFF_FFFF_FFFF);
            chk(done_cyc == 1 && err_seen, {tag, " R9 done+err"}, 64'(done_cyc), 64'd1);
            chk(rf_writes == 0, {tag, " R9 no rf write"}, 64'(rf_writes), 64'd0);
        end else begin
            chk(sp_cyc == e_n + 1, {tag, " R6 sp cycle"}, 64'(sp_cyc), 64'(e_n + 1));
            chk(sp_val == (sv ? sp - 32'(fr) : sp + 32'(fr)), {tag, " R6 sp value"},
                64'(sp_val), 64'(sv ? sp - 32'(fr) : sp + 32'(fr)));
            chk(done_cyc == e_n + 2 && !err_seen, {tag, " R6 done cycle"}, 64'(done_cyc), 64'(e_n + 2));
            chk(rf_writes == (sv ? 0 : e_n), {tag, " rf write count"}, 64'(rf_writes), 64'(sv ? 0 : e_n));
        end
    endtask

    task automatic t_reset;
        chk(!busy_o && !done_o && !err_o, "R1 idle flags", {61'd0, busy_o, done_o, err_o}, 64'd0);
        chk(!mem_en_o && !rf_we_o && !sp_we_o, "R1 idle strobes", {61'd0, mem_en_o, rf_we_o, sp_we_o}, 64'd0);
    endtask

    task automatic init_state;
        for (int r = 0; r < 32; r++) rf[r] = {32'h5A5A0000 + 32'(r), 32'h11110000 + 32'(r) * 32'h101};
        for (int i = 0; i < 256; i++) mem[i] = i[0] ? (32'h80000000 | 32'(i * 7)) : (32'h00001000 + 32'(i));
    endtask

    initial begin
        init_state();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        run_op(1, 1, 1, 1, 3'd7, 4'd14, 12'h040, 32'h200, 0, "R2 R3 R4 save full");
        run_op(1, 0, 1, 0, 3'd2, 4'd11, 12'h020, 32'h200, 0, "R5 R4 save statics code11");
        run_op(1, 1, 0, 0, 3'd0, 4'd13, 12'h018, 32'h200, 0, "R2 R5 save code13");
        run_op(1, 0, 0, 0, 3'd0, 4'd0,  12'h008, 32'h200, 0, "R6 save empty");
        init_state();
        run_op(0, 1, 1, 1, 3'd3, 4'd7,  12'h048, 32'h180, 0, "R7 R8 restore");
        run_op(0, 0, 1, 0, 3'd7, 4'd14, 12'h030, 32'h180, 0, "R7 restore no args");
        run_op(1, 1, 0, 1, 3'd1, 4'd15, 12'h040, 32'h200, 0, "R9 reserved");
        run_op(1, 1, 1, 0, 3'd4, 4'd9,  12'h028, 32'h200, 1, "R10 start while busy");
        @(negedge clk);
        t_reset();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule